// File: doc/BRIEF.md
# DRAM Command Reordering Scheduler

This block sits between one local request port and a DRAM command path. Incoming read and write commands go into an eight-entry queue. Each cycle the block offers one queued command downstream. The choice is not strict arrival order. An entry whose wait has reached a programmable limit goes first. A high-priority request comes next. After that comes a command whose row is already open in its bank, and then the oldest remaining command. A younger command never passes an older queued command to the same bank, row and column.

Every accepted read gets a tag from a reorder buffer. The downstream path returns read data tagged in any order. The buffer hands the data back to the requester strictly in the order the reads were accepted. The downstream path reports row activations and precharges. From these the block keeps its own table of open rows, one entry per bank.

Top module: `dram_reorder_sched`

## Requirements
- R1: After reset, `req_ready` is 1, `cmd_valid` is 0 and `rsp_valid` is 0.
- R2: When no entry is starved, high priority or a row hit, commands are issued in the order they were accepted. `cmd_valid` is 1 exactly when the queue holds at least one entry.
- R3: An entry whose bank has an open row equal to its row is issued before older entries that miss.
- R4: An entry whose bank, row and column equal those of an older queued entry is not issued until that older entry has been issued, even when it is flagged high priority.
- R5: An entry accepted with `req_prio`=1 is issued before older normal entries and before row-hit entries.
- R6: Each queued entry's age starts at 0 on acceptance and rises by one per clock, saturating at its maximum. An entry whose age is at least `starve_limit` is issued before any high-priority or row-hit entry.
- R7: Among several entries of the same selection class, the oldest one is issued first.
- R8: Read data returned on `rd_*` with any tag order appears on `rsp_valid`/`rsp_data` in acceptance order. It appears one cycle per entry, in the cycle after the head read's data is stored, and never before all older reads have been released.
- R9: `req_ready` is 0 while the queue holds 8 entries, and also while 8 accepted reads have not yet been released on the response side.
- R10: Reads take tags in acceptance order, starting at 0 after reset and counting up modulo 8. A read's tag appears on `cmd_tag` when it is issued.
- R11: `act_valid` marks `act_row` as open in `act_bank`. `pre_valid` closes `pre_bank`. An entry counts as a row hit only while its own row is the one open in its bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| starve_limit | input | 8 | Age at which an entry is forced out |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_prio | input | 1 | High-priority request |
| req_bank | input | 3 | Request bank |
| req_row | input | 14 | Request row |
| req_col | input | 10 | Request column |
| cmd_valid | output | 1 | A command is offered downstream |
| cmd_ready | input | 1 | Downstream takes the offered command |
| cmd_write | output | 1 | 1 = write, 0 = read |
| cmd_bank | output | 3 | Command bank |
| cmd_row | output | 14 | Command row |
| cmd_col | output | 10 | Command column |
| cmd_tag | output | 3 | Read tag for data return |
| act_valid | input | 1 | Row activated downstream |
| act_bank | input | 3 | Activated bank |
| act_row | input | 14 | Activated row |
| pre_valid | input | 1 | Bank precharged downstream |
| pre_bank | input | 3 | Precharged bank |
| rd_valid | input | 1 | Read data returned from memory |
| rd_tag | input | 3 | Tag of returned data |
| rd_data | input | 32 | Returned data |
| rsp_valid | output | 1 | In-order read data valid |
| rsp_data | output | 32 | In-order read data |

## Verification
Short batches are queued while `cmd_ready` is held low and then drained one command at a time. The entries in each batch differ in a single attribute: priority, open-row match, age, or an address shared with an older entry. The issue order therefore shows which selection rule won. A pair with the same address but different direction separates the collision rule from the priority rule. Opening a row and then asking for a different row in that bank separates a true hit from a bank-only match. Read data is returned out of order, with the last read first, to confirm that the head read holds back everything after it. Filling the queue with writes, and keeping eight reads in flight with no data returned, exercises each of the two accept stalls on its own.

// File: rtl/rsched_pkg.sv
package rsched_pkg;
    parameter int DEPTH  = 8;
    parameter int QIDX_W = $clog2(DEPTH);
    parameter int BANK_W = 3;
    parameter int NBANK  = 1 << BANK_W;
    parameter int ROW_W  = 14;
    parameter int COL_W  = 10;
    parameter int AGE_W  = 8;
    parameter int TAG_W  = 3;
    parameter int NTAG   = 1 << TAG_W;
    parameter int DATA_W = 32;

    typedef struct packed {
        logic              vld;
        logic              wr;
        logic              prio;
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic [AGE_W-1:0]  age;
        logic [TAG_W-1:0]  tag;
    } qent_t;
endpackage

// File: rtl/rsched_rowtab.sv
module rsched_rowtab
    import rsched_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         act_valid,
    input  logic [BANK_W-1:0]            act_bank,
    input  logic [ROW_W-1:0]             act_row,
    input  logic                         pre_valid,
    input  logic [BANK_W-1:0]            pre_bank,
    output logic [NBANK-1:0]             open_v,
    output logic [NBANK-1:0][ROW_W-1:0]  open_row
);
    typedef struct packed {
        logic [NBANK-1:0]            v;
        logic [NBANK-1:0][ROW_W-1:0] row;
    } tab_t;

    tab_t tab_d, tab_q;

    always_comb begin
        tab_d = tab_q;
        if (pre_valid) tab_d.v[pre_bank] = 1'b0;
        if (act_valid) begin
            tab_d.v[act_bank]   = 1'b1;
            tab_d.row[act_bank] = act_row;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tab_q <= '0;
        else        tab_q <= tab_d;
    end

    assign open_v   = tab_q.v;
    assign open_row = tab_q.row;
endmodule

// File: rtl/rsched_pick.sv
module rsched_pick
    import rsched_pkg::*;
(
    input  qent_t [DEPTH-1:0]            q,
    input  logic  [NBANK-1:0]            open_v,
    input  logic  [NBANK-1:0][ROW_W-1:0] open_row,
    input  logic  [AGE_W-1:0]            starve_limit,
    output logic                         sel_valid,
    output logic  [QIDX_W-1:0]           sel_idx
);
    logic [DEPTH-1:0] elig, starved, urgent, hit, cls;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            logic blocked;
            blocked = 1'b0;
            // an older entry with the same address holds this one back
            for (int j = 0; j < DEPTH; j++) begin
                if (j < i && q[j].vld && q[j].bank == q[i].bank &&
                    q[j].row == q[i].row && q[j].col == q[i].col)
                    blocked = 1'b1;
            end
            elig[i]    = q[i].vld && !blocked;
            starved[i] = elig[i] && (q[i].age >= starve_limit);
            urgent[i]  = elig[i] && q[i].prio;
            hit[i]     = elig[i] && open_v[q[i].bank] &&
                         (open_row[q[i].bank] == q[i].row);
        end

        if      (|starved) cls = starved;
        else if (|urgent)  cls = urgent;
        else if (|hit)     cls = hit;
        else               cls = elig;

        // index 0 is the oldest slot, so the lowest set bit wins
        sel_valid = |cls;
        sel_idx   = '0;
        for (int k = DEPTH - 1; k >= 0; k--) begin
            if (cls[k]) sel_idx = QIDX_W'(k);
        end
    end
endmodule

// File: rtl/rsched_rob.sv
module rsched_rob
    import rsched_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc,
    output logic [TAG_W-1:0]  alloc_tag,
    output logic              rob_free,
    input  logic              rd_valid,
    input  logic [TAG_W-1:0]  rd_tag,
    input  logic [DATA_W-1:0] rd_data,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data
);
    typedef struct packed {
        logic [TAG_W-1:0]             head;
        logic [TAG_W-1:0]             tail;
        logic [TAG_W:0]               used;
        logic [NTAG-1:0]              pres;
        logic [NTAG-1:0][DATA_W-1:0]  data;
    } rob_t;

    rob_t rob_d, rob_q;
    logic pop;

    assign pop = rob_q.pres[rob_q.head];

    always_comb begin
        rob_d = rob_q;
        if (pop) begin
            rob_d.pres[rob_q.head] = 1'b0;
            rob_d.head             = rob_q.head + 1'b1;
        end
        if (alloc) rob_d.tail = rob_q.tail + 1'b1;
        rob_d.used = rob_q.used + (TAG_W+1)'(alloc) - (TAG_W+1)'(pop);
        if (rd_valid) begin
            rob_d.pres[rd_tag] = 1'b1;
            rob_d.data[rd_tag] = rd_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rob_q <= '0;
        else        rob_q <= rob_d;
    end

    assign alloc_tag = rob_q.tail;
    assign rob_free  = rob_q.used < (TAG_W+1)'(NTAG);
    assign rsp_valid = pop;
    assign rsp_data  = rob_q.data[rob_q.head];
endmodule

// File: rtl/dram_reorder_sched.sv
module dram_reorder_sched
    import rsched_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AGE_W-1:0]  starve_limit,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic              req_prio,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic              cmd_write,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ROW_W-1:0]  cmd_row,
    output logic [COL_W-1:0]  cmd_col,
    output logic [TAG_W-1:0]  cmd_tag,
    input  logic              act_valid,
    input  logic [BANK_W-1:0] act_bank,
    input  logic [ROW_W-1:0]  act_row,
    input  logic              pre_valid,
    input  logic [BANK_W-1:0] pre_bank,
    input  logic              rd_valid,
    input  logic [TAG_W-1:0]  rd_tag,
    input  logic [DATA_W-1:0] rd_data,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data
);
    typedef struct packed {
        qent_t [DEPTH-1:0] q;
        logic  [QIDX_W:0]  cnt;
    } st_t;

    st_t st_d, st_q;

    logic                        sel_valid;
    logic [QIDX_W-1:0]           sel_idx;
    logic [NBANK-1:0]            open_v;
    logic [NBANK-1:0][ROW_W-1:0] open_row;
    logic                        rob_free;
    logic [TAG_W-1:0]            alloc_tag;
    logic                        issue, accept;
    qent_t                       sel_e;
    qent_t [DEPTH:0]             ext;
    logic [QIDX_W:0]             base;

    rsched_rowtab u_rowtab (
        .clk, .rst_n, .act_valid, .act_bank, .act_row,
        .pre_valid, .pre_bank, .open_v, .open_row
    );

    rsched_pick u_pick (
        .q(st_q.q), .open_v, .open_row, .starve_limit,
        .sel_valid, .sel_idx
    );

    rsched_rob u_rob (
        .clk, .rst_n, .alloc(accept && !req_write), .alloc_tag, .rob_free,
        .rd_valid, .rd_tag, .rd_data, .rsp_valid, .rsp_data
    );

    assign req_ready = (st_q.cnt < (QIDX_W+1)'(DEPTH)) && rob_free;
    assign accept    = req_valid && req_ready;
    assign issue     = sel_valid && cmd_ready;

    assign sel_e     = st_q.q[sel_idx];
    assign cmd_valid = sel_valid;
    assign cmd_write = sel_e.wr;
    assign cmd_bank  = sel_e.bank;
    assign cmd_row   = sel_e.row;
    assign cmd_col   = sel_e.col;
    assign cmd_tag   = sel_e.tag;

    always_comb begin
        st_d = st_q;
        ext  = {qent_t'('0), st_q.q};
        // close the gap left by the issued entry, then age the survivors
        for (int i = 0; i < DEPTH; i++) begin
            if (issue && i >= int'(sel_idx)) st_d.q[i] = ext[i+1];
            else                             st_d.q[i] = ext[i];
            if (st_d.q[i].vld && st_d.q[i].age != '1)
                st_d.q[i].age = st_d.q[i].age + 1'b1;
        end
        base = st_q.cnt - (QIDX_W+1)'(issue);
        if (accept) begin
            st_d.q[base[QIDX_W-1:0]] = '{vld: 1'b1, wr: req_write, prio: req_prio,
                                         bank: req_bank, row: req_row, col: req_col,
                                         age: '0, tag: alloc_tag};
        end
        st_d.cnt = base + (QIDX_W+1)'(accept);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/rsched_chk.sv
module rsched_chk
    import rsched_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic req_write,
    input logic cmd_valid,
    input logic cmd_ready,
    input logic rsp_valid
);
    logic [QIDX_W:0] occ;
    logic [TAG_W:0]  outst;
    logic            acc;

    assign acc = req_valid && req_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            occ   <= '0;
            outst <= '0;
        end else begin
            occ   <= occ + (QIDX_W+1)'(acc) - (QIDX_W+1)'(cmd_valid && cmd_ready);
            outst <= outst + (TAG_W+1)'(acc && !req_write) - (TAG_W+1)'(rsp_valid);
        end
    end

    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!cmd_valid && !rsp_valid));

    a_r2_offer_needs_entry: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> occ != '0);

    a_r2_entry_is_offered: assert property (@(posedge clk) disable iff (!rst_n)
        occ != '0 |-> cmd_valid);

    a_r9_queue_full_stall: assert property (@(posedge clk) disable iff (!rst_n)
        occ == (QIDX_W+1)'(DEPTH) |-> !req_ready);

    a_r9_tags_exhausted_stall: assert property (@(posedge clk) disable iff (!rst_n)
        outst == (TAG_W+1)'(NTAG) |-> !req_ready);

    a_r8_rsp_has_read: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> outst != '0);
endmodule

bind dram_reorder_sched rsched_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .rsp_valid(rsp_valid)
);

// File: tb/dram_reorder_sched_tb.sv
module dram_reorder_sched_tb;
    import rsched_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [AGE_W-1:0]  starve_limit = '1;
    logic              req_valid = 1'b0, req_write = 1'b0, req_prio = 1'b0;
    logic [BANK_W-1:0] req_bank = '0;
    logic [ROW_W-1:0]  req_row = '0;
    logic [COL_W-1:0]  req_col = '0;
    logic              req_ready, cmd_valid, cmd_write;
    logic              cmd_ready = 1'b0;
    logic [BANK_W-1:0] cmd_bank;
    logic [ROW_W-1:0]  cmd_row;
    logic [COL_W-1:0]  cmd_col;
    logic [TAG_W-1:0]  cmd_tag;
    logic              act_valid = 1'b0, pre_valid = 1'b0;
    logic [BANK_W-1:0] act_bank = '0, pre_bank = '0;
    logic [ROW_W-1:0]  act_row = '0;
    logic              rd_valid = 1'b0;
    logic [TAG_W-1:0]  rd_tag = '0;
    logic [DATA_W-1:0] rd_data = '0;
    logic              rsp_valid;
    logic [DATA_W-1:0] rsp_data;

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dram_reorder_sched u_dut (.*);

    task automatic chk(input string r, input longint act, input longint exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", r, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cmd_ready = 1'b0;
        starve_limit = '1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic push(input bit wr, input bit pr, input int bank, input int row, input int col);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_prio = pr;
        req_bank = BANK_W'(bank); req_row = ROW_W'(row); req_col = COL_W'(col);
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic open_row(input int bank, input int row);
        @(negedge clk);
        act_valid = 1'b1; act_bank = BANK_W'(bank); act_row = ROW_W'(row);
        @(posedge clk); #1;
        act_valid = 1'b0;
    endtask

    task automatic close_bank(input int bank);
        @(negedge clk);
        pre_valid = 1'b1; pre_bank = BANK_W'(bank);
        @(posedge clk); #1;
        pre_valid = 1'b0;
    endtask

    task automatic ret(input int tag, input int data);
        @(negedge clk);
        rd_valid = 1'b1; rd_tag = TAG_W'(tag); rd_data = DATA_W'(data);
        @(posedge clk); #1;
        rd_valid = 1'b0;
    endtask

    // take one command; wr or tag below 0 means not checked
    task automatic take(input string r, input int col, input int wr, input int tag);
        @(negedge clk);
        cmd_ready = 1'b1;
        chk({r, " cmd_valid"}, cmd_valid, 1);
        chk({r, " cmd_col"}, cmd_col, col);
        if (wr >= 0)  chk({r, " cmd_write"}, cmd_write, wr);
        if (tag >= 0) chk({r, " cmd_tag"}, cmd_tag, tag);
        @(posedge clk); #1;
        cmd_ready = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        @(negedge clk);
        chk("R1 req_ready", req_ready, 1);
        chk("R1 cmd_valid", cmd_valid, 0);
        chk("R1 rsp_valid", rsp_valid, 0);
    endtask

    task automatic t_fifo();
        do_reset();
        push(1, 0, 1, 1, 1);
        push(0, 0, 2, 1, 2);
        push(1, 0, 3, 1, 3);
        take("R2 fifo", 1, 1, -1);
        take("R2 fifo", 2, 0, -1);
        take("R2 fifo", 3, 1, -1);
        @(negedge clk);
        chk("R2 empty cmd_valid", cmd_valid, 0);
    endtask

    task automatic t_row_hit();
        do_reset();
        open_row(2, 5);
        push(1, 0, 1, 1, 10);
        push(1, 0, 2, 5, 11);
        push(1, 0, 2, 6, 12);
        take("R3 hit first", 11, -1, -1);
        take("R11 other row no hit", 10, -1, -1);
        take("R11 other row last", 12, -1, -1);
        close_bank(2);
        push(1, 0, 1, 1, 20);
        push(1, 0, 2, 5, 21);
        take("R11 closed bank no hit", 20, -1, -1);
        take("R11 closed bank", 21, -1, -1);
    endtask

    task automatic t_collision();
        do_reset();
        push(0, 0, 1, 1, 50);
        push(1, 0, 5, 2, 51);
        push(0, 1, 5, 2, 51);
        take("R4 prio blocked", 50, 0, -1);
        take("R4 older same address", 51, 1, -1);
        take("R4 younger same address", 51, 0, -1);
    endtask

    task automatic t_prio();
        do_reset();
        open_row(2, 5);
        push(1, 0, 1, 1, 60);
        push(1, 0, 2, 5, 61);
        push(1, 1, 3, 1, 62);
        take("R5 prio over hit", 62, -1, -1);
        take("R5 hit next", 61, -1, -1);
        take("R5 oldest last", 60, -1, -1);
    endtask

    task automatic t_ties();
        do_reset();
        push(1, 0, 1, 1, 70);
        push(1, 1, 2, 1, 71);
        push(1, 1, 3, 1, 72);
        take("R7 older prio", 71, -1, -1);
        take("R7 younger prio", 72, -1, -1);
        take("R7 normal", 70, -1, -1);
    endtask

    task automatic t_starve();
        do_reset();
        starve_limit = 8'd5;
        open_row(2, 5);
        push(1, 0, 1, 1, 80);
        repeat (6) @(posedge clk);
        push(1, 1, 3, 1, 81);
        push(1, 0, 2, 5, 82);
        take("R6 starved first", 80, -1, -1);
        take("R6 prio next", 81, -1, -1);
        take("R6 hit last", 82, -1, -1);
    endtask

    task automatic t_in_order();
        do_reset();
        push(0, 0, 1, 1, 1);
        push(0, 0, 2, 1, 2);
        push(0, 0, 3, 1, 3);
        take("R10 tag", 1, 0, 0);
        take("R10 tag", 2, 0, 1);
        take("R10 tag", 3, 0, 2);
        ret(2, 32'hC3);
        @(negedge clk);
        chk("R8 youngest held", rsp_valid, 0);
        ret(0, 32'hA1);
        @(negedge clk);
        chk("R8 first valid", rsp_valid, 1);
        chk("R8 first data", rsp_data, 32'hA1);
        ret(1, 32'hB2);
        @(negedge clk);
        chk("R8 second valid", rsp_valid, 1);
        chk("R8 second data", rsp_data, 32'hB2);
        @(negedge clk);
        chk("R8 third valid", rsp_valid, 1);
        chk("R8 third data", rsp_data, 32'hC3);
        @(negedge clk);
        chk("R8 drained", rsp_valid, 0);
    endtask

    task automatic t_queue_full();
        do_reset();
        for (int k = 0; k < DEPTH; k++) push(1, 0, k % NBANK, 1, 100 + k);
        @(negedge clk);
        chk("R9 queue full ready", req_ready, 0);
        take("R9 drain one", 100, 1, -1);
        @(negedge clk);
        chk("R9 slot freed ready", req_ready, 1);
    endtask

    task automatic t_tags_full();
        do_reset();
        for (int k = 0; k < NTAG; k++) push(0, 0, k % NBANK, 2, 200 + k);
        for (int k = 0; k < NTAG; k++) take("R10 tag run", 200 + k, 0, k);
        @(negedge clk);
        chk("R9 tags exhausted ready", req_ready, 0);
        ret(0, 32'h55);
        @(negedge clk);
        chk("R9 head pending ready", req_ready, 0);
        chk("R8 head released", rsp_data, 32'h55);
        @(negedge clk);
        chk("R9 tag freed ready", req_ready, 1);
    endtask

    initial begin
        t_reset();
        t_fifo();
        t_row_hit();
        t_collision();
        t_prio();
        t_ties();
        t_starve();
        t_in_order();
        t_queue_full();
        t_tags_full();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule